// File: doc/BRIEF.md
# Debug Serial Channel Bridge

The bridge links a debugger to a core through a set of independent serial channels. Each channel has two small queues. One carries words from the debugger to the core. The other carries words from the core to the debugger. The debugger reaches the bridge through a three-register access port, and each access completes in the cycle it is presented. One register holds status and the channel select. A second register is the transmit register, which pushes words and reads back the last accepted word. A third is the receive register, which pops words. On the core side, each channel has a valid/ready source interface that delivers debugger words and a valid/ready sink interface that accepts core words.

Every channel keeps a sticky error flag. The flag is raised by an overflow (a push into a full queue) or by an underflow (a pop from an empty queue). While the flag is set, the channel refuses all data traffic. The debugger clears the flag by writing a one to it. Selecting a channel index that the build does not provide makes the data registers inert.

Top module: `dbg_serial_bridge`

## Requirements
- R1: The register index on `reg_sel` is 0 for status, 1 for transmit and 2 for receive. A status read returns CH_COUNT in bits 31:28, zero in bit 27 and the selected channel in bits 26:24. A status write loads bits 26:24 into the channel select. Reset selects channel 0.
- R2: For each existing channel n, status bit 3n+2 is its error flag, bit 3n+1 is set while its core-to-debugger queue is non-empty, and bit 3n is set while its debugger-to-core queue is full. Bits that belong to no existing channel read zero.
- R3: A transmit write to the selected channel, made while its error flag is clear and its debugger-to-core queue is not full, pushes the word without raising `reg_err`. The core receives the pushed words on `core_pop_*` in the order they were written.
- R4: A transmit write made while the queue is full or the error flag is set pushes nothing, raises `reg_err` in that cycle and sets the error flag.
- R5: A receive read made while the error flag is clear and the core-to-debugger queue is non-empty returns the oldest word and removes it. Words come back in the order the core pushed them.
- R6: A receive read made while that queue is empty or the error flag is set returns zero, removes nothing, raises `reg_err` and sets the error flag.
- R7: An error flag stays set until a status write carries a one at that channel's bit 3n+2. A zero at that bit leaves the flag unchanged.
- R8: A transmit read returns the last word the selected channel's queue accepted, or zero if it has accepted none since reset. It never raises `reg_err`.
- R9: While the select is at or above CH_COUNT, transmit and receive accesses change nothing, read zero and never raise `reg_err`.
- R10: Each queue holds QDEPTH words. The full bit sets after QDEPTH accepted pushes, and `core_push_ready` drops once the core-to-debugger queue holds QDEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Debugger access strobe, one access per cycle |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_sel | input | 2 | Register index (0 status, 1 transmit, 2 receive) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access, zero for writes |
| reg_err | output | 1 | Access failed, valid in the cycle of the access |
| core_push_valid | input | CH_COUNT | Core offers a word per channel |
| core_push_data | input | 32*CH_COUNT | Core words, channel n in bits 32n+31:32n |
| core_push_ready | output | CH_COUNT | Core-to-debugger queue has room |
| core_pop_valid | output | CH_COUNT | Debugger word available per channel |
| core_pop_data | output | 32*CH_COUNT | Oldest debugger word, channel n in bits 32n+31:32n |
| core_pop_ready | input | CH_COUNT | Core takes the offered word |

## Verification
The bench builds the bridge with CH_COUNT=3 and QDEPTH=4. With three channels, select values 3 to 7 name channels that do not exist, so the inert-channel rule is exercised at the ports. A depth of four lets a handful of pushes fill a queue from each side, which brings the overflow, underflow and sticky-flag paths within reach. Reading the status word then shows where each channel's flags sit.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned MAX_CH  = 8;
   localparam int unsigned SEL_W   = 3;
   localparam int unsigned CNT_LSB = 28;
   localparam int unsigned SEL_LSB = 24;

   typedef enum logic [1:0] {
      REG_STAT = 2'd0,
      REG_TX   = 2'd1,
      REG_RX   = 2'd2,
      REG_NONE = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic err;
      logic avail;
      logic full;
   } ch_flags_t;
endpackage

// File: rtl/dsq_fifo.sv
module dsq_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_depth_chk
      $error("dsq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          push, pop;

   assign in_ready  = (cnt != CW'(DEPTH));
   assign out_valid = (cnt != '0);
   assign out_data  = mem[rp];
   assign push      = in_valid & in_ready;
   assign pop       = out_valid & out_ready;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/dsq_channel.sv
module dsq_channel
   import dsq_pkg::*;
#(
   parameter int unsigned QDEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic              err_clr,
   output ch_flags_t         flags,
   output logic [WORD_W-1:0] head_word,
   output logic [WORD_W-1:0] last_word,
   output logic              fail,
   input  logic              cin_valid,
   input  logic [WORD_W-1:0] cin_data,
   output logic              cin_ready,
   output logic              cout_valid,
   output logic [WORD_W-1:0] cout_data,
   input  logic              cout_ready
);
   logic err_q;
   logic d2c_room;
   logic c2d_avail;
   logic push_ok;
   logic pop_ok;

   assign push_ok = wr_req & ~err_q & d2c_room;
   assign pop_ok  = rd_req & ~err_q & c2d_avail;
   assign fail    = (wr_req & ~push_ok) | (rd_req & ~pop_ok);

   dsq_fifo #(.W(WORD_W), .DEPTH(QDEPTH)) u_d2c (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (wr_req & ~err_q),
      .in_data  (wr_data),
      .in_ready (d2c_room),
      .out_valid(cout_valid),
      .out_data (cout_data),
      .out_ready(cout_ready)
   );

   dsq_fifo #(.W(WORD_W), .DEPTH(QDEPTH)) u_c2d (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cin_valid),
      .in_data  (cin_data),
      .in_ready (cin_ready),
      .out_valid(c2d_avail),
      .out_data (head_word),
      .out_ready(rd_req & ~err_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q     <= 1'b0;
         last_word <= '0;
      end else begin
         if (fail)         err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         if (push_ok) last_word <= wr_data;
      end
   end

   assign flags.err   = err_q;
   assign flags.avail = c2d_avail;
   assign flags.full  = ~d2c_room;
endmodule

// File: rtl/dbg_serial_bridge.sv
module dbg_serial_bridge
   import dsq_pkg::*;
#(
   parameter int unsigned CH_COUNT = 4,
   parameter int unsigned QDEPTH   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_req,
   input  logic                       reg_wr,
   input  logic [1:0]                 reg_sel,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   output logic                       reg_err,
   input  logic [CH_COUNT-1:0]        core_push_valid,
   input  logic [CH_COUNT*WORD_W-1:0] core_push_data,
   output logic [CH_COUNT-1:0]        core_push_ready,
   output logic [CH_COUNT-1:0]        core_pop_valid,
   output logic [CH_COUNT*WORD_W-1:0] core_pop_data,
   input  logic [CH_COUNT-1:0]        core_pop_ready
);
   localparam int unsigned FLAG_W = 3 * MAX_CH;

   if (CH_COUNT < 1 || CH_COUNT > MAX_CH) begin : g_count_chk
      $error("dbg_serial_bridge: CH_COUNT must be 1..8");
   end
   if (QDEPTH < 2) begin : g_qdepth_chk
      $error("dbg_serial_bridge: QDEPTH must be at least 2");
   end

   logic [SEL_W-1:0]  sel_q;
   logic              sel_ok;
   logic              is_stat_wr, is_stat_rd, is_tx_wr, is_tx_rd, is_rx_rd;
   logic [CH_COUNT-1:0] ch_wr, ch_rd, ch_clr, ch_fail;
   logic [CH_COUNT-1:0] ch_err, ch_avail, ch_full;
   ch_flags_t         ch_flags [CH_COUNT];
   logic [WORD_W-1:0] ch_head  [CH_COUNT];
   logic [WORD_W-1:0] ch_last  [CH_COUNT];
   logic [FLAG_W-1:0] flag_bits;
   logic [WORD_W-1:0] last_sel, head_sel;
   logic              err_sel, avail_sel;

   assign sel_ok     = ({1'b0, sel_q} < 4'(CH_COUNT));
   assign is_stat_wr = reg_req &  reg_wr & (reg_sel == REG_STAT);
   assign is_stat_rd = reg_req & ~reg_wr & (reg_sel == REG_STAT);
   assign is_tx_wr   = reg_req &  reg_wr & (reg_sel == REG_TX);
   assign is_tx_rd   = reg_req & ~reg_wr & (reg_sel == REG_TX);
   assign is_rx_rd   = reg_req & ~reg_wr & (reg_sel == REG_RX);

   for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
      assign ch_wr[n]  = is_tx_wr & sel_ok & (sel_q == SEL_W'(n));
      assign ch_rd[n]  = is_rx_rd & sel_ok & (sel_q == SEL_W'(n));
      assign ch_clr[n] = is_stat_wr & reg_wdata[3*n+2];

      dsq_channel #(.QDEPTH(QDEPTH)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_req    (ch_wr[n]),
         .wr_data   (reg_wdata),
         .rd_req    (ch_rd[n]),
         .err_clr   (ch_clr[n]),
         .flags     (ch_flags[n]),
         .head_word (ch_head[n]),
         .last_word (ch_last[n]),
         .fail      (ch_fail[n]),
         .cin_valid (core_push_valid[n]),
         .cin_data  (core_push_data[n*WORD_W +: WORD_W]),
         .cin_ready (core_push_ready[n]),
         .cout_valid(core_pop_valid[n]),
         .cout_data (core_pop_data[n*WORD_W +: WORD_W]),
         .cout_ready(core_pop_ready[n])
      );

      assign ch_err[n]   = ch_flags[n].err;
      assign ch_avail[n] = ch_flags[n].avail;
      assign ch_full[n]  = ch_flags[n].full;
   end

   always_comb begin
      flag_bits = '0;
      last_sel  = '0;
      head_sel  = '0;
      err_sel   = 1'b0;
      avail_sel = 1'b0;
      for (int n = 0; n < int'(CH_COUNT); n++) begin
         flag_bits[3*n +: 3] = {ch_err[n], ch_avail[n], ch_full[n]};
         if (sel_q == SEL_W'(n)) begin
            last_sel  = ch_last[n];
            head_sel  = ch_head[n];
            err_sel   = ch_err[n];
            avail_sel = ch_avail[n];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (is_stat_rd) begin
         reg_rdata = {4'(CH_COUNT), 1'b0, sel_q, flag_bits};
      end else if (is_tx_rd && sel_ok) begin
         reg_rdata = last_sel;
      end else if (is_rx_rd && sel_ok && !err_sel && avail_sel) begin
         reg_rdata = head_sel;
      end
   end

   assign reg_err = |ch_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sel_q <= '0;
      else if (is_stat_wr) sel_q <= reg_wdata[SEL_LSB +: SEL_W];
   end
endmodule

// File: rtl/dsq_bridge_chk.sv
module dsq_bridge_chk #(
   parameter int unsigned CH_COUNT = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_req,
   input logic                reg_wr,
   input logic [1:0]          reg_sel,
   input logic [31:0]         reg_wdata,
   input logic [31:0]         reg_rdata,
   input logic                reg_err,
   input logic [2:0]          sel_q,
   input logic [CH_COUNT-1:0] ch_err,
   input logic [CH_COUNT-1:0] ch_avail,
   input logic [CH_COUNT-1:0] ch_full
);
   logic stat_wr, stat_rd, tx_wr, rx_rd, absent;
   assign stat_wr = reg_req &  reg_wr & (reg_sel == 2'd0);
   assign stat_rd = reg_req & ~reg_wr & (reg_sel == 2'd0);
   assign tx_wr   = reg_req &  reg_wr & (reg_sel == 2'd1);
   assign rx_rd   = reg_req & ~reg_wr & (reg_sel == 2'd2);
   assign absent  = ({1'b0, sel_q} >= 4'(CH_COUNT));

   AST_COUNT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (reg_rdata[31:28] == 4'(CH_COUNT)) && (reg_rdata[26:24] == sel_q)); // R1
   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> (sel_q == $past(reg_wdata[26:24]))); // R1
   AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_sel != 2'd0 && absent) |-> (!reg_err && reg_rdata == 32'd0)); // R9

   for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
      AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_err[n] && !(stat_wr && reg_wdata[3*n+2])) |=> ch_err[n]); // R7
      AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_wr && reg_wdata[3*n+2]) |=> !ch_err[n]); // R7
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_wr && sel_q == 3'(n) && ch_full[n]) |-> reg_err); // R4
      AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_rd && sel_q == 3'(n) && !ch_avail[n]) |-> (reg_err && reg_rdata == 32'd0)); // R6
      AST_FAIL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_err && sel_q == 3'(n)) |=> ch_err[n]); // R4 R6
   end
endmodule

bind dbg_serial_bridge dsq_bridge_chk #(.CH_COUNT(CH_COUNT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_req  (reg_req),
   .reg_wr   (reg_wr),
   .reg_sel  (reg_sel),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .reg_err  (reg_err),
   .sel_q    (sel_q),
   .ch_err   (ch_err),
   .ch_avail (ch_avail),
   .ch_full  (ch_full)
);

// File: tb/dbg_serial_bridge_tb.sv
module dbg_serial_bridge_tb_top;
   localparam int NCH = 3;
   localparam int QD  = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_req = 1'b0;
   logic               reg_wr = 1'b0;
   logic [1:0]         reg_sel = 2'd0;
   logic [31:0]        reg_wdata = '0;
   logic [31:0]        reg_rdata;
   logic               reg_err;
   logic [NCH-1:0]     core_push_valid = '0;
   logic [NCH*32-1:0]  core_push_data = '0;
   logic [NCH-1:0]     core_push_ready;
   logic [NCH-1:0]     core_pop_valid;
   logic [NCH*32-1:0]  core_pop_data;
   logic [NCH-1:0]     core_pop_ready = '0;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   dbg_serial_bridge #(.CH_COUNT(NCH), .QDEPTH(QD)) dut_i (.*);

   // vector: {tag[3:0], sel[1:0], wr, wdata[31:0], exp_rdata[31:0], exp_err}
   localparam int NV = 25;
   localparam logic [71:0] VEC [NV] = '{
      {4'd1, 2'd0, 1'b0, 32'h0,         32'h3000_0000, 1'b0}, // R1 reset status
      {4'd8, 2'd1, 1'b0, 32'h0,         32'h0,         1'b0}, // R8 reset readback
      {4'd1, 2'd0, 1'b1, 32'h0100_0000, 32'h0,         1'b0}, // R1 select ch1
      {4'd1, 2'd0, 1'b0, 32'h0,         32'h3100_0000, 1'b0}, // R1
      {4'd3, 2'd1, 1'b1, 32'h0000_00A1, 32'h0,         1'b0}, // R3
      {4'd3, 2'd1, 1'b1, 32'h0000_00A2, 32'h0,         1'b0}, // R3
      {4'd3, 2'd1, 1'b1, 32'h0000_00A3, 32'h0,         1'b0}, // R3
      {4'd3, 2'd1, 1'b1, 32'h0000_00A4, 32'h0,         1'b0}, // R3
      {4'd10,2'd0, 1'b0, 32'h0,         32'h3100_0008, 1'b0}, // R10 R2 full bit
      {4'd4, 2'd1, 1'b1, 32'h0000_00A5, 32'h0,         1'b1}, // R4 overflow
      {4'd2, 2'd0, 1'b0, 32'h0,         32'h3100_0028, 1'b0}, // R2 error bit
      {4'd8, 2'd1, 1'b0, 32'h0,         32'h0000_00A4, 1'b0}, // R8 last accepted
      {4'd4, 2'd1, 1'b1, 32'h0000_00B0, 32'h0,         1'b1}, // R4 blocked by err
      {4'd7, 2'd0, 1'b1, 32'h0100_0000, 32'h0,         1'b0}, // R7 zero keeps
      {4'd7, 2'd0, 1'b0, 32'h0,         32'h3100_0028, 1'b0}, // R7
      {4'd7, 2'd0, 1'b1, 32'h0100_0020, 32'h0,         1'b0}, // R7 clear
      {4'd7, 2'd0, 1'b0, 32'h0,         32'h3100_0008, 1'b0}, // R7
      {4'd6, 2'd2, 1'b0, 32'h0,         32'h0,         1'b1}, // R6 underflow
      {4'd6, 2'd0, 1'b0, 32'h0,         32'h3100_0028, 1'b0}, // R6
      {4'd7, 2'd0, 1'b1, 32'h0100_0020, 32'h0,         1'b0}, // R7
      {4'd9, 2'd0, 1'b1, 32'h0500_0000, 32'h0,         1'b0}, // R9 absent select
      {4'd9, 2'd1, 1'b1, 32'h0000_00CC, 32'h0,         1'b0}, // R9
      {4'd9, 2'd1, 1'b0, 32'h0,         32'h0,         1'b0}, // R9
      {4'd9, 2'd2, 1'b0, 32'h0,         32'h0,         1'b0}, // R9
      {4'd9, 2'd0, 1'b0, 32'h0,         32'h3500_0008, 1'b0}  // R9 ch1 untouched
   };

   task automatic check(input bit ok, input int tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_op(input int tag, input logic [1:0] sel, input logic wr,
                         input logic [31:0] wd, input logic [31:0] exp, input logic exp_err);
      @(posedge clk); #1;
      reg_req = 1'b1; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      @(negedge clk);
      check(reg_rdata == exp, tag, reg_rdata, exp);
      check(reg_err == exp_err, tag, {31'd0, reg_err}, {31'd0, exp_err});
      @(posedge clk); #1;
      reg_req = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic core_take(input int ch, input logic [31:0] exp);
      @(negedge clk);
      check(core_pop_valid[ch] == 1'b1, 3, {31'd0, core_pop_valid[ch]}, 32'd1);
      check(core_pop_data[ch*32 +: 32] == exp, 3, core_pop_data[ch*32 +: 32], exp);
      core_pop_ready[ch] = 1'b1;
      @(posedge clk); #1;
      core_pop_ready[ch] = 1'b0;
   endtask

   task automatic core_give(input int ch, input logic [31:0] w, input logic exp_rdy);
      @(posedge clk); #1;
      core_push_valid[ch] = 1'b1;
      core_push_data[ch*32 +: 32] = w;
      @(negedge clk);
      check(core_push_ready[ch] == exp_rdy, 10, {31'd0, core_push_ready[ch]}, {31'd0, exp_rdy});
      @(posedge clk); #1;
      core_push_valid[ch] = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(core_push_ready == 3'b111, 10, {29'd0, core_push_ready}, 32'd7); // R10 reset
      check(core_pop_valid == 3'b000, 3, {29'd0, core_pop_valid}, 32'd0);    // R3 reset

      for (int i = 0; i < NV; i++) begin
         reg_op(int'(VEC[i][71:68]), VEC[i][67:66], VEC[i][65], VEC[i][64:33],
                VEC[i][32:1], VEC[i][0]);
      end

      // R3: core drains channel 1 in write order
      for (int k = 0; k < 4; k++) core_take(1, 32'hA1 + k);
      @(negedge clk);
      check(core_pop_valid[1] == 1'b0, 3, {31'd0, core_pop_valid[1]}, 32'd0);
      reg_op(2, 2'd0, 1'b0, 32'h0, 32'h3500_0000, 1'b0); // R2 full cleared

      // R10: core fills channel 2, fifth offer refused
      for (int k = 0; k < 4; k++) core_give(2, 32'hC0 + k, 1'b1);
      core_give(2, 32'hDD, 1'b0);
      reg_op(1, 2'd0, 1'b1, 32'h0200_0000, 32'h0, 1'b0);
      reg_op(2, 2'd0, 1'b0, 32'h0, 32'h3200_0080, 1'b0); // R2 valid bit 7

      // R5: debugger pops in core order
      for (int k = 0; k < 4; k++) reg_op(5, 2'd2, 1'b0, 32'h0, 32'hC0 + k, 1'b0);
      reg_op(5, 2'd0, 1'b0, 32'h0, 32'h3200_0000, 1'b0);
      reg_op(6, 2'd2, 1'b0, 32'h0, 32'h0, 1'b1);          // R6 empty again
      reg_op(6, 2'd0, 1'b0, 32'h0, 32'h3200_0100, 1'b0);  // error bit 8

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule